// File: doc/BRIEF.md
# Polyphase Lookup-Table Memory-Polynomial Predistorter

This block is a complex-baseband predistortion datapath. It takes four consecutive samples in each clock, one in each polyphase lane, and returns four predistorted samples. Each output sample is a sum over delay taps m = 0..MEM_DEPTH. Each term is the delayed input sample x[n−m] multiplied by a complex gain. That gain is read from a table that belongs to tap m and is addressed by the squared magnitude of that same delayed sample. Any polynomial coefficients are folded into the table contents beforehand, so the hardware only looks up a gain and multiplies once per tap.

Both stream interfaces use valid/ready. A beat moves when valid and ready are both high at a rising clock edge. The pipeline runs in lock-step under one enable, which is high whenever the output register is empty or the sink is ready. Back-pressure from the sink therefore freezes every stage and drops `in_ready` in the same cycle. The gain tables are loaded through a plain write port, and only while the stream is idle.

Top module: `mp_predistorter`

## Requirements
- R1: A beat carries four lanes. Lane p uses bits [32p+31:32p+16] for I and [32p+15:32p] for Q, both 16-bit two's complement, and lane 0 is the oldest sample. For each lane the block computes the complex sum over m of x[n−m]·g_m. The product is re = xI·gR − xQ·gI and im = xI·gI + xQ·gR, where the table entries are 18-bit signed values with 14 fractional bits.
- R2: For lane p and tap m, x[n−m] is lane p−m of the same beat when p−m ≥ 0. Otherwise it is lane p−m+4 of the previous accepted beat. Beats with in_valid low do not advance this history. MEM_DEPTH may range from 1 to 4.
- R3: Tap m reads its own table at address min(63, floor((I²+Q²)/2^24)) of the delayed sample x[n−m]. A magnitude of 2^30 or more maps to address 63.
- R4: Each accepted beat yields exactly one output beat, in order. With out_ready held high, the output beat is valid on the fourth rising edge after the edge that accepted the input.
- R5: in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R6: Each output component is (sum + 2^13) shifted arithmetically right by 14, then saturated to the range −32768..32767.
- R7: When wr_en is high at an edge, the entry at (wr_tap, wr_adr) takes the value (wr_re, wr_im). Every beat accepted afterwards uses the new value. Writes are allowed only while in_valid is low and no beat is in flight.
- R8: While rst_n is low, out_valid is low and the history is cleared. The first beat after reset therefore uses zero for samples from before reset. Table contents survive reset.
- R9: If tap 0 holds 16384+0j at every address and all other taps hold zero, every output beat equals the corresponding input beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_data | input | 128 | Four input lanes, I/Q packed as in R1 |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Sink takes the beat this cycle |
| out_data | output | 128 | Four predistorted lanes, same packing |
| wr_en | input | 1 | Table write strobe |
| wr_tap | input | 2 | Tap whose table is written |
| wr_adr | input | 6 | Table address written |
| wr_re | input | 18 | Real part of the gain written |
| wr_im | input | 18 | Imaginary part of the gain written |

## Verification
The assertions assume that table writes arrive only when the stream is empty: in_valid is low and nothing is in flight. Otherwise a beat in the pipe could read an entry half-way through a reload. The bench respects this by draining the pipeline before every reload, waiting until every expected output has left with out_ready high. Samples are accepted only on the handshake edge, so the stimulus may change in_data freely while in_valid is low, and the bench holds the data stable while a beat waits for in_ready. Back-pressure is randomized in some phases but held off in the pass-through phase, where the exact latency is checked.

// File: rtl/mp_pkg.sv
package mp_pkg;

  // number of polyphase lanes handled per clock
  localparam int LANES = 4;
  localparam int LANE_IW = $clog2(LANES);

  // lane that supplies the sample delayed by m for output lane p
  function automatic int src_lane(input int p, input int m);
    return (p - m >= 0) ? (p - m) : (p - m + LANES);
  endfunction

  // whether that sample comes from the previous accepted beat
  function automatic bit src_prev(input int p, input int m);
    return (p - m) < 0;
  endfunction

endpackage

// File: rtl/mp_tap_gather.sv
module mp_tap_gather
  import mp_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 6,
  parameter int TAPS = 3
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 take,
  input  logic signed [DW-1:0] in_re  [LANES],
  input  logic signed [DW-1:0] in_im  [LANES],
  output logic signed [DW-1:0] tap_re [LANES][TAPS],
  output logic signed [DW-1:0] tap_im [LANES][TAPS],
  output logic [AW-1:0]        tap_adr[LANES][TAPS]
);

  localparam int MW     = 2*DW + 1;
  localparam int FS_BIT = 2*DW - 2;

  logic signed [DW-1:0] cur_re [LANES];
  logic signed [DW-1:0] cur_im [LANES];
  logic signed [DW-1:0] prv_re [LANES];
  logic signed [DW-1:0] prv_im [LANES];

  logic signed [DW-1:0] sel_re [LANES][TAPS];
  logic signed [DW-1:0] sel_im [LANES][TAPS];
  logic [AW-1:0]        sel_adr[LANES][TAPS];

  // current beat and the beat before it; only accepted beats shift in
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < LANES; p++) begin
        cur_re[p] <= '0;
        cur_im[p] <= '0;
        prv_re[p] <= '0;
        prv_im[p] <= '0;
      end
    end else if (take) begin
      for (int p = 0; p < LANES; p++) begin
        cur_re[p] <= in_re[p];
        cur_im[p] <= in_im[p];
        prv_re[p] <= cur_re[p];
        prv_im[p] <= cur_im[p];
      end
    end
  end

  // pick the delayed sample for each lane/tap and form its table address
  always_comb begin
    for (int p = 0; p < LANES; p++) begin
      for (int m = 0; m < TAPS; m++) begin
        logic signed [2*DW-1:0] sq_i;
        logic signed [2*DW-1:0] sq_q;
        logic [MW-1:0]          mag;
        if (src_prev(p, m)) begin
          sel_re[p][m] = prv_re[LANE_IW'(src_lane(p, m))];
          sel_im[p][m] = prv_im[LANE_IW'(src_lane(p, m))];
        end else begin
          sel_re[p][m] = cur_re[LANE_IW'(src_lane(p, m))];
          sel_im[p][m] = cur_im[LANE_IW'(src_lane(p, m))];
        end
        sq_i = sel_re[p][m] * sel_re[p][m];
        sq_q = sel_im[p][m] * sel_im[p][m];
        mag  = {1'b0, sq_i} + {1'b0, sq_q};
        if (mag >= (MW'(1) << FS_BIT))
          sel_adr[p][m] = '1;
        else
          sel_adr[p][m] = mag[FS_BIT-1 -: AW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      for (int p = 0; p < LANES; p++) begin
        for (int m = 0; m < TAPS; m++) begin
          tap_re[p][m]  <= sel_re[p][m];
          tap_im[p][m]  <= sel_im[p][m];
          tap_adr[p][m] <= sel_adr[p][m];
        end
      end
    end
  end

endmodule

// File: rtl/mp_gain_lut.sv
module mp_gain_lut
  import mp_pkg::*;
#(
  parameter int CW   = 18,
  parameter int AW   = 6,
  parameter int TAPS = 3,
  parameter int TB   = 2
)(
  input  logic                 clk,
  input  logic                 en,
  input  logic                 wr_en,
  input  logic [TB-1:0]        wr_tap,
  input  logic [AW-1:0]        wr_adr,
  input  logic signed [CW-1:0] wr_re,
  input  logic signed [CW-1:0] wr_im,
  input  logic [AW-1:0]        rd_adr [LANES][TAPS],
  output logic signed [CW-1:0] g_re   [LANES][TAPS],
  output logic signed [CW-1:0] g_im   [LANES][TAPS]
);

  localparam int DEPTH = 1 << AW;

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    logic signed [CW-1:0] mem_re [DEPTH];
    logic signed [CW-1:0] mem_im [DEPTH];
    logic signed [CW-1:0] rd_re  [LANES];
    logic signed [CW-1:0] rd_im  [LANES];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_tap == TB'(t))) begin
        mem_re[wr_adr] <= wr_re;
        mem_im[wr_adr] <= wr_im;
      end
    end

    // one read port per lane on this tap's table
    always_ff @(posedge clk) begin
      if (en) begin
        for (int p = 0; p < LANES; p++) begin
          rd_re[p] <= mem_re[rd_adr[p][t]];
          rd_im[p] <= mem_im[rd_adr[p][t]];
        end
      end
    end

    for (genvar p = 0; p < LANES; p++) begin : g_lane
      assign g_re[p][t] = rd_re[p];
      assign g_im[p][t] = rd_im[p];
    end
  end

endmodule

// File: rtl/mp_lane_mac.sv
module mp_lane_mac #(
  parameter int DW    = 16,
  parameter int CW    = 18,
  parameter int CFRAC = 14,
  parameter int TAPS  = 3
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 sum_vld,
  input  logic signed [DW-1:0] x_re [TAPS],
  input  logic signed [DW-1:0] x_im [TAPS],
  input  logic signed [CW-1:0] g_re [TAPS],
  input  logic signed [CW-1:0] g_im [TAPS],
  output logic signed [DW-1:0] y_re,
  output logic signed [DW-1:0] y_im
);

  localparam int PW = DW + CW + 1;
  localparam int SW = PW + $clog2(TAPS + 1) + 1;
  localparam logic signed [SW-1:0] YMAX = SW'((64'sd1 <<< (DW-1)) - 64'sd1);
  localparam logic signed [SW-1:0] YMIN = -YMAX - SW'(1);
  localparam logic signed [SW-1:0] HALF = SW'(64'sd1 <<< (CFRAC-1));

  logic signed [PW-1:0] pr_re [TAPS];
  logic signed [PW-1:0] pr_im [TAPS];
  logic signed [SW-1:0] acc_re, acc_im, rnd_re, rnd_im;

  // stage C: one complex product per tap
  always_ff @(posedge clk) begin
    if (en) begin
      for (int t = 0; t < TAPS; t++) begin
        pr_re[t] <= PW'(x_re[t]) * PW'(g_re[t]) - PW'(x_im[t]) * PW'(g_im[t]);
        pr_im[t] <= PW'(x_re[t]) * PW'(g_im[t]) + PW'(x_im[t]) * PW'(g_re[t]);
      end
    end
  end

  always_comb begin
    acc_re = '0;
    acc_im = '0;
    for (int t = 0; t < TAPS; t++) begin
      acc_re = acc_re + SW'(pr_re[t]);
      acc_im = acc_im + SW'(pr_im[t]);
    end
    rnd_re = (acc_re + HALF) >>> CFRAC;
    rnd_im = (acc_im + HALF) >>> CFRAC;
  end

  function automatic logic signed [DW-1:0] clip(input logic signed [SW-1:0] v);
    if (v > YMAX)      return YMAX[DW-1:0];
    else if (v < YMIN) return YMIN[DW-1:0];
    else               return v[DW-1:0];
  endfunction

  // stage D: round, saturate, register
  always_ff @(posedge clk) begin
    if (en) begin
      y_re <= clip(rnd_re);
      y_im <= clip(rnd_im);
    end
  end

  assert_sat_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sum_vld && (rnd_re > YMAX)) |=> (y_re == YMAX[DW-1:0]));

  assert_sat_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sum_vld && (rnd_im < YMIN)) |=> (y_im == YMIN[DW-1:0]));

endmodule

// File: rtl/mp_predistorter.sv
module mp_predistorter
  import mp_pkg::*;
#(
  parameter int MEM_DEPTH = 2,
  parameter int DW        = 16,
  parameter int CW        = 18,
  parameter int CFRAC     = 14,
  parameter int AW        = 6,
  localparam int TB       = (MEM_DEPTH > 0) ? $clog2(MEM_DEPTH + 1) : 1,
  localparam int BW       = LANES * 2 * DW
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [BW-1:0]        in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [BW-1:0]        out_data,
  input  logic                 wr_en,
  input  logic [TB-1:0]        wr_tap,
  input  logic [AW-1:0]        wr_adr,
  input  logic signed [CW-1:0] wr_re,
  input  logic signed [CW-1:0] wr_im
);

  localparam int TAPS   = MEM_DEPTH + 1;
  localparam int LW     = 2 * DW;
  localparam int STAGES = 5;

  logic [STAGES-1:0] vld;
  logic en, take;

  assign en        = !vld[STAGES-1] || out_ready;
  assign in_ready  = en;
  assign take      = in_valid && en;
  assign out_valid = vld[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n)  vld <= '0;
    else if (en) vld <= {vld[STAGES-2:0], in_valid};
  end

  logic signed [DW-1:0] in_re [LANES];
  logic signed [DW-1:0] in_im [LANES];
  logic signed [DW-1:0] ta_re [LANES][TAPS];
  logic signed [DW-1:0] ta_im [LANES][TAPS];
  logic [AW-1:0]        ta_adr[LANES][TAPS];
  logic signed [DW-1:0] xb_re [LANES][TAPS];
  logic signed [DW-1:0] xb_im [LANES][TAPS];
  logic signed [CW-1:0] g_re  [LANES][TAPS];
  logic signed [CW-1:0] g_im  [LANES][TAPS];
  logic signed [DW-1:0] y_re  [LANES];
  logic signed [DW-1:0] y_im  [LANES];

  for (genvar p = 0; p < LANES; p++) begin : g_io
    assign in_re[p] = in_data[p*LW + DW +: DW];
    assign in_im[p] = in_data[p*LW +: DW];
    assign out_data[p*LW + DW +: DW] = y_re[p];
    assign out_data[p*LW +: DW]      = y_im[p];
  end

  mp_tap_gather #(.DW(DW), .AW(AW), .TAPS(TAPS)) u_gather (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .take   (take),
    .in_re  (in_re),
    .in_im  (in_im),
    .tap_re (ta_re),
    .tap_im (ta_im),
    .tap_adr(ta_adr)
  );

  mp_gain_lut #(.CW(CW), .AW(AW), .TAPS(TAPS), .TB(TB)) u_lut (
    .clk   (clk),
    .en    (en),
    .wr_en (wr_en),
    .wr_tap(wr_tap),
    .wr_adr(wr_adr),
    .wr_re (wr_re),
    .wr_im (wr_im),
    .rd_adr(ta_adr),
    .g_re  (g_re),
    .g_im  (g_im)
  );

  // align the samples with the table read latency
  always_ff @(posedge clk) begin
    if (en) begin
      for (int p = 0; p < LANES; p++) begin
        for (int m = 0; m < TAPS; m++) begin
          xb_re[p][m] <= ta_re[p][m];
          xb_im[p][m] <= ta_im[p][m];
        end
      end
    end
  end

  for (genvar p = 0; p < LANES; p++) begin : g_mac
    mp_lane_mac #(.DW(DW), .CW(CW), .CFRAC(CFRAC), .TAPS(TAPS)) u_mac (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .sum_vld(vld[STAGES-2]),
      .x_re   (xb_re[p]),
      .x_im   (xb_im[p]),
      .g_re   (g_re[p]),
      .g_im   (g_im[p]),
      .y_re   (y_re[p]),
      .y_im   (y_im[p])
    );
  end

  // occupancy seen at the ports, used only by the checks below
  logic [3:0] inflight;
  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 4'(take) - 4'(out_valid && out_ready);
  end

  assert_inflight_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 4'(STAGES));

  assert_out_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (inflight != 0));

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_idle_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!in_valid && (inflight == 0)));

endmodule

// File: tb/mp_predistorter_tb_top.sv
module mp_predistorter_tb_top;

  localparam int TAPS = 3;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         in_valid = 0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1;
  logic [127:0] out_data;
  logic         wr_en = 0;
  logic [1:0]   wr_tap = '0;
  logic [5:0]   wr_adr = '0;
  logic [17:0]  wr_re = '0;
  logic [17:0]  wr_im = '0;

  always #4 clk = ~clk;

  mp_predistorter dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .wr_en(wr_en), .wr_tap(wr_tap), .wr_adr(wr_adr), .wr_re(wr_re), .wr_im(wr_im)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit rnd_rdy = 0;
  bit exact_lat = 0;
  string cur_req = "R1";

  longint lut_re [TAPS][64];
  longint lut_im [TAPS][64];
  longint prv_re [4];
  longint prv_im [4];

  logic [127:0] exp_q [$];
  int           exp_t [$];
  bit           hold_prev = 0;
  logic [127:0] held;

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // behavioural model of one beat; advances the model's history
  function automatic logic [127:0] model(input logic [127:0] d);
    longint cr [4];
    longint ci [4];
    logic [127:0] r;
    for (int p = 0; p < 4; p++) begin
      cr[p] = $signed(d[p*32+16 +: 16]);
      ci[p] = $signed(d[p*32 +: 16]);
    end
    for (int p = 0; p < 4; p++) begin
      longint ar = 0;
      longint ai = 0;
      for (int m = 0; m < TAPS; m++) begin
        longint xr, xi, mag, gr, gi;
        int a;
        if (p - m >= 0) begin xr = cr[p-m]; xi = ci[p-m]; end
        else begin xr = prv_re[p-m+4]; xi = prv_im[p-m+4]; end
        mag = xr*xr + xi*xi;
        a = (mag >= (64'sd1 << 30)) ? 63 : int'(mag / (64'sd1 << 24));
        gr = lut_re[m][a];
        gi = lut_im[m][a];
        ar += xr*gr - xi*gi;
        ai += xr*gi + xi*gr;
      end
      r[p*32+16 +: 16] = 16'(sat16((ar + 8192) >>> 14));
      r[p*32 +: 16]    = 16'(sat16((ai + 8192) >>> 14));
    end
    for (int p = 0; p < 4; p++) begin prv_re[p] = cr[p]; prv_im[p] = ci[p]; end
    return r;
  endfunction

  // reference comparison, sampled on the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      hold_prev = 0;
    end else begin
      cyc++;
      check(in_ready == (!out_valid || out_ready), "R5 in_ready", {127'd0, in_ready}, {127'd0, (!out_valid || out_ready)});
      if (hold_prev)
        check(out_valid && (out_data == held), "R5 hold", out_data, held);
      if (in_valid && in_ready) begin
        exp_q.push_back(model(in_data));
        exp_t.push_back(cyc);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R4 unexpected beat", out_data, '0);
        end else begin
          logic [127:0] e;
          int t0;
          e = exp_q.pop_front();
          t0 = exp_t.pop_front();
          check(out_data == e, cur_req, out_data, e);
          if (exact_lat)
            check(cyc - t0 == 5, "R4 latency", 128'(cyc - t0), 128'd5);
        end
      end
      hold_prev = out_valid && !out_ready;
      held = out_data;
    end
  end

  initial begin
    out_ready = 1;
    forever begin
      @(posedge clk); #1;
      out_ready = rnd_rdy ? ($urandom_range(0, 3) != 0) : 1'b1;
    end
  end

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 0; in_valid = 0;
    repeat (3) @(posedge clk);
    #1;
    for (int p = 0; p < 4; p++) begin prv_re[p] = 0; prv_im[p] = 0; end
    exp_q.delete(); exp_t.delete();
    @(negedge clk);
    check(out_valid == 0, "R8 out_valid in reset", {127'd0, out_valid}, '0);
    @(posedge clk); #1;
    rst_n = 1;
  endtask

  task automatic wr(input int t, input int a, input longint re, input longint im);
    wr_en = 1; wr_tap = 2'(t); wr_adr = 6'(a); wr_re = 18'(re); wr_im = 18'(im);
    lut_re[t][a] = re; lut_im[t][a] = im;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic send(input logic [127:0] d);
    in_data = d; in_valid = 1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic drain();
    in_valid = 0;
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  function automatic logic [127:0] rand_beat(input int span);
    logic [127:0] d;
    for (int k = 0; k < 8; k++) d[k*16 +: 16] = 16'($urandom_range(0, 2*span) - span);
    return d;
  endfunction

  function automatic logic [15:0] pick_edge();
    int v;
    case ($urandom_range(0, 9))
      0: v = 0;       1: v = 4095;   2: v = 4096;   3: v = -4096;
      4: v = 23170;   5: v = 23171;  6: v = 32767;  7: v = -32768;
      8: v = -32767;  default: v = 100;
    endcase
    return 16'(v);
  endfunction

  initial begin
    do_reset();
    @(negedge clk);
    check(in_ready == 1, "R8 in_ready after reset", {127'd0, in_ready}, 128'd1);

    // identity tables: pass-through and exact latency
    for (int a = 0; a < 64; a++) begin
      wr(0, a, 16384, 0);
      for (int t = 1; t < TAPS; t++) wr(t, a, 0, 0);
    end
    cur_req = "R9 pass-through"; exact_lat = 1; rnd_rdy = 0;
    for (int i = 0; i < 24; i++) send(rand_beat(32768));
    drain();
    exact_lat = 0;

    // random tables, fresh history, gaps and back-pressure
    for (int t = 0; t < TAPS; t++)
      for (int a = 0; a < 64; a++)
        wr(t, a, $urandom_range(0, 32767) - 16384, $urandom_range(0, 32767) - 16384);
    do_reset();
    cur_req = "R1/R2/R8 tap sum"; rnd_rdy = 1;
    for (int i = 0; i < 60; i++) begin
      send(rand_beat(20000));
      repeat ($urandom_range(0, 2)) @(posedge clk);
      #1;
    end
    drain();

    // table rewrite while idle
    rnd_rdy = 0;
    for (int a = 0; a < 64; a++) wr(1, a, 12000 - a*300, a*150);
    cur_req = "R7 rewritten table"; rnd_rdy = 1;
    for (int i = 0; i < 30; i++) send(rand_beat(32768));
    drain();

    // address boundaries, distinct entry per address
    rnd_rdy = 0;
    for (int t = 0; t < TAPS; t++)
      for (int a = 0; a < 64; a++) wr(t, a, (a - 32)*256 + t*7, a*16 - t*5);
    cur_req = "R3 address edges";
    for (int i = 0; i < 60; i++) begin
      logic [127:0] d;
      for (int k = 0; k < 8; k++) d[k*16 +: 16] = pick_edge();
      send(d);
    end
    drain();

    // large gains into saturation, both signs
    for (int t = 0; t < TAPS; t++)
      for (int a = 0; a < 64; a++) wr(t, a, 32000, (a % 2) ? 9000 : -9000);
    cur_req = "R6 saturation"; rnd_rdy = 1;
    for (int i = 0; i < 30; i++) begin
      logic [127:0] d;
      int sg;
      sg = (i % 2) ? 1 : -1;
      for (int k = 0; k < 8; k++) d[k*16 +: 16] = 16'(sg * $urandom_range(20000, 32767));
      send(d);
    end
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired, pending=%0d expected=0", exp_q.size());
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule